// File: doc/BRIEF.md
# Two-Phase DRAM Command Pair Decoder

This block sits at the command input of a double-data-rate DRAM device whose accesses are issued as two back-to-back command cycles rather than one row/column decode. The first cycle names the bank and an upper address and says whether the access is a read or a write. Both kinds close the row by themselves once the access is done. The second cycle either supplies the lower address, which completes the access, or turns the pair into a mode-register load. All inputs are sampled on the rising clock edge.

The decoder emits a one-cycle operation strobe together with the assembled bank, upper and lower address fields. For a mode-register pair it emits a load strobe, a regular/extended select and the data word. It keeps a busy indication from the first command through a configurable burst window after the completing cycle. It flags a second cycle that breaks the pair protocol, and it flags an active-low power-down request that arrives while an access is in progress. Every output is a register, and a synchronous active-high reset returns the block to idle.

Top module: `cmd_pair_decoder`

## Requirements
- R1: A reset cycle (`rst`=1 at a rising edge) clears every output to zero and abandons any half-formed pair. A second-cycle command after reset produces no output.
- R2: A first command is `cs_i`=0 with `fn_i`=1 (read) or `fn_i`=0 (write) while idle. It latches `ba_i` and `addr_i[14:0]` and produces no strobe. `busy_o` is 1 in the cycle after it.
- R3: A lower-address command (`cs_i`=1, `fn_i`=0) directly after a first command raises `op_valid_o` for exactly one cycle after that edge. In that cycle `op_upper_o` is the first-cycle address, `op_lower_o` is `addr_i[6:0]` of the second cycle, and `op_write_o` is 1 for a write.
- R4: `op_bank_o` equals the first-cycle `{ba_i[1], ba_i[0]}`, covering banks 0 to 3.
- R5: A mode-register command (`cs_i`=1, `fn_i`=1) directly after a first command raises `mreg_load_o` for one cycle. `mreg_ext_o` is the first-cycle `ba_i[0]` (0 selects the regular register, 1 the extended one). `mreg_data_o` is the first-cycle `addr_i[14:0]`. No operation strobe is produced.
- R6: A cycle with `cs_i`=0 directly after a first command aborts the pair. `proto_err_o` pulses for one cycle, no operation or load strobe is produced, and the decoder returns to idle without starting a new pair.
- R7: A cycle with `cs_i`=1 while idle is a no-operation and produces no strobe.
- R8: After a completing lower-address cycle, `busy_o` stays 1 for exactly `BURST_LEN` cycles and then falls. After a mode-register or aborted pair with no burst running, `busy_o` is 0 in the next cycle.
- R9: `pd_err_o` is 1 in the cycle after an edge at which `pd_n_i`=0 while `busy_o` was 1. It is 0 after an edge at which `pd_n_i`=1 or `busy_o` was 0.
- R10: At most one of `op_valid_o`, `mreg_load_o` and `proto_err_o` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_i | input | 1 | Chip select, first/second cycle marker |
| fn_i | input | 1 | Function control, paired with cs_i |
| ba_i | input | 2 | Bank select / mode-register select |
| addr_i | input | 15 | Address and mode data |
| pd_n_i | input | 1 | Power-down request, active low |
| op_valid_o | output | 1 | Completed access strobe |
| op_write_o | output | 1 | Completed access is a write |
| op_bank_o | output | 2 | Bank of the completed access |
| op_upper_o | output | 15 | Upper address of the completed access |
| op_lower_o | output | 7 | Lower address of the completed access |
| mreg_load_o | output | 1 | Mode-register load strobe |
| mreg_ext_o | output | 1 | 1 selects the extended mode register |
| mreg_data_o | output | 15 | Mode-register data |
| proto_err_o | output | 1 | Broken pair pulse |
| busy_o | output | 1 | Access in progress |
| pd_err_o | output | 1 | Illegal power-down request |

## Verification
Completion of an access and the illegal power-down flag can fall in the same cycle, because the decoder is already busy when the lower-address cycle arrives. The bench drives `pd_n_i` low on exactly that cycle. The scoreboard then checks the operation strobe and its fields in the same sampled cycle in which a direct check expects `pd_err_o`. A burst window that has not yet run out is also crossed by a new pair, so that the pair's busy period and the old countdown overlap. In that case, and after a power-down request that arrives while idle, the bench checks that no flag is raised.

// File: rtl/ndec_pkg.sv
package ndec_pkg;
  // command code is {cs, fn}; the decoder relies on this bit layout
  typedef enum logic [1:0] {
    CMD_WR    = 2'b00,
    CMD_RD    = 2'b01,
    CMD_LOWER = 2'b10,
    CMD_MREG  = 2'b11
  } cmd_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_PEND = 1'b1
  } pair_st_e;
endpackage

// File: rtl/ndec_classify.sv
module ndec_classify
  import ndec_pkg::*;
(
  input  logic cs_i,
  input  logic fn_i,
  output cmd_e cmd_o,
  output logic is_first_o,
  output logic is_second_o
);
  always_comb begin
    cmd_o       = cmd_e'({cs_i, fn_i});
    is_first_o  = (cmd_o == CMD_WR) || (cmd_o == CMD_RD);
    is_second_o = (cmd_o == CMD_LOWER) || (cmd_o == CMD_MREG);
  end
endmodule

// File: rtl/ndec_pair_fsm.sv
module ndec_pair_fsm
  import ndec_pkg::*;
#(
  parameter int BANK_W  = 2,
  parameter int UPPER_W = 15,
  parameter int LOWER_W = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  cmd_e               cmd_i,
  input  logic               is_first_i,
  input  logic               is_second_i,
  input  logic [BANK_W-1:0]  ba_i,
  input  logic [UPPER_W-1:0] addr_i,
  output logic               pend_o,
  output logic               start_o,
  output logic               op_valid_o,
  output logic               op_write_o,
  output logic [BANK_W-1:0]  op_bank_o,
  output logic [UPPER_W-1:0] op_upper_o,
  output logic [LOWER_W-1:0] op_lower_o,
  output logic               mreg_load_o,
  output logic               mreg_ext_o,
  output logic [UPPER_W-1:0] mreg_data_o,
  output logic               proto_err_o
);
  pair_st_e           st_q;
  logic               wr_q;
  logic [BANK_W-1:0]  bank_q;
  logic [UPPER_W-1:0] upper_q;

  assign pend_o  = (st_q == ST_PEND);
  assign start_o = pend_o && (cmd_i == CMD_LOWER);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      wr_q        <= 1'b0;
      bank_q      <= '0;
      upper_q     <= '0;
      op_valid_o  <= 1'b0;
      op_write_o  <= 1'b0;
      op_bank_o   <= '0;
      op_upper_o  <= '0;
      op_lower_o  <= '0;
      mreg_load_o <= 1'b0;
      mreg_ext_o  <= 1'b0;
      mreg_data_o <= '0;
      proto_err_o <= 1'b0;
    end else begin
      op_valid_o  <= 1'b0;
      mreg_load_o <= 1'b0;
      proto_err_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (is_first_i) begin
            st_q    <= ST_PEND;
            wr_q    <= (cmd_i == CMD_WR);
            bank_q  <= ba_i;
            upper_q <= addr_i;
          end
        end
        ST_PEND: begin
          st_q <= ST_IDLE;
          if (is_second_i && cmd_i == CMD_LOWER) begin
            op_valid_o <= 1'b1;
            op_write_o <= wr_q;
            op_bank_o  <= bank_q;
            op_upper_o <= upper_q;
            op_lower_o <= addr_i[LOWER_W-1:0];
          end else if (is_second_i) begin
            mreg_load_o <= 1'b1;
            mreg_ext_o  <= bank_q[0];
            mreg_data_o <= upper_q;
          end else begin
            proto_err_o <= 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  a_r6_abort: assert property (@(posedge clk) disable iff (rst)
    (pend_o && is_first_i) |=> (proto_err_o && !pend_o && !op_valid_o));
  a_r7_idle_nop: assert property (@(posedge clk) disable iff (rst)
    (!pend_o && is_second_i) |=> (!op_valid_o && !mreg_load_o && !proto_err_o));
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
    op_valid_o |=> !op_valid_o);
  a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({op_valid_o, mreg_load_o, proto_err_o}));
  a_r2_first_latch: assert property (@(posedge clk) disable iff (rst)
    (!pend_o && is_first_i) |=> (pend_o && !op_valid_o && !mreg_load_o));
endmodule

// File: rtl/ndec_burst_timer.sv
module ndec_burst_timer #(
  parameter int BURST_LEN = 4,
  localparam int CNT_W = $clog2(BURST_LEN + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic active_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (start_i)       cnt_q <= CNT_W'(BURST_LEN);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign active_o = (cnt_q != '0);

  a_r8_reload: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (cnt_q == CNT_W'(BURST_LEN)));
  a_r8_countdown: assert property (@(posedge clk) disable iff (rst)
    (active_o && !start_i) |=> (cnt_q == CNT_W'($past(cnt_q) - 1'b1)));
endmodule

// File: rtl/ndec_pd_guard.sv
module ndec_pd_guard (
  input  logic clk,
  input  logic rst,
  input  logic pd_n_i,
  input  logic busy_i,
  output logic pd_err_o
);
  always_ff @(posedge clk) begin
    if (rst) pd_err_o <= 1'b0;
    else     pd_err_o <= !pd_n_i && busy_i;
  end

  a_r9_flag: assert property (@(posedge clk) disable iff (rst)
    (!pd_n_i && busy_i) |=> pd_err_o);
  a_r9_quiet: assert property (@(posedge clk) disable iff (rst)
    (pd_n_i || !busy_i) |=> !pd_err_o);
endmodule

// File: rtl/cmd_pair_decoder.sv
module cmd_pair_decoder
  import ndec_pkg::*;
#(
  parameter int BANK_W    = 2,
  parameter int UPPER_W   = 15,
  parameter int LOWER_W   = 7,
  parameter int BURST_LEN = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cs_i,
  input  logic               fn_i,
  input  logic [BANK_W-1:0]  ba_i,
  input  logic [UPPER_W-1:0] addr_i,
  input  logic               pd_n_i,
  output logic               op_valid_o,
  output logic               op_write_o,
  output logic [BANK_W-1:0]  op_bank_o,
  output logic [UPPER_W-1:0] op_upper_o,
  output logic [LOWER_W-1:0] op_lower_o,
  output logic               mreg_load_o,
  output logic               mreg_ext_o,
  output logic [UPPER_W-1:0] mreg_data_o,
  output logic               proto_err_o,
  output logic               busy_o,
  output logic               pd_err_o
);
  cmd_e cmd;
  logic is_first, is_second, pend, start, burst_active;

  ndec_classify u_cls (
    .cs_i       (cs_i),
    .fn_i       (fn_i),
    .cmd_o      (cmd),
    .is_first_o (is_first),
    .is_second_o(is_second)
  );

  ndec_pair_fsm #(
    .BANK_W (BANK_W),
    .UPPER_W(UPPER_W),
    .LOWER_W(LOWER_W)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .cmd_i      (cmd),
    .is_first_i (is_first),
    .is_second_i(is_second),
    .ba_i       (ba_i),
    .addr_i     (addr_i),
    .pend_o     (pend),
    .start_o    (start),
    .op_valid_o (op_valid_o),
    .op_write_o (op_write_o),
    .op_bank_o  (op_bank_o),
    .op_upper_o (op_upper_o),
    .op_lower_o (op_lower_o),
    .mreg_load_o(mreg_load_o),
    .mreg_ext_o (mreg_ext_o),
    .mreg_data_o(mreg_data_o),
    .proto_err_o(proto_err_o)
  );

  ndec_burst_timer #(.BURST_LEN(BURST_LEN)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .start_i (start),
    .active_o(burst_active)
  );

  assign busy_o = pend || burst_active;

  ndec_pd_guard u_pd (
    .clk     (clk),
    .rst     (rst),
    .pd_n_i  (pd_n_i),
    .busy_i  (busy_o),
    .pd_err_o(pd_err_o)
  );

  initial begin
    if (LOWER_W > UPPER_W || BURST_LEN < 1 || BANK_W < 1)
      $error("cmd_pair_decoder: bad parameters");
  end

  a_r8_busy_on_op: assert property (@(posedge clk) disable iff (rst)
    op_valid_o |-> busy_o);
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!op_valid_o && !mreg_load_o && !proto_err_o && !busy_o && !pd_err_o));
endmodule

// File: tb/tb_cmd_pair_decoder.sv
module tb_cmd_pair_decoder;
  localparam int BURST = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs = 1'b1, fn = 1'b0, pdn = 1'b1;
  logic [1:0] ba = '0;
  logic [14:0] addr = '0;
  logic op_valid, op_write, mreg_load, mreg_ext, proto_err, busy, pd_err;
  logic [1:0] op_bank;
  logic [14:0] op_upper, mreg_data;
  logic [6:0] op_lower;

  always #2.5 clk = ~clk;

  cmd_pair_decoder #(.BURST_LEN(BURST)) dut (
    .clk(clk), .rst(rst), .cs_i(cs), .fn_i(fn), .ba_i(ba), .addr_i(addr),
    .pd_n_i(pdn), .op_valid_o(op_valid), .op_write_o(op_write),
    .op_bank_o(op_bank), .op_upper_o(op_upper), .op_lower_o(op_lower),
    .mreg_load_o(mreg_load), .mreg_ext_o(mreg_ext), .mreg_data_o(mreg_data),
    .proto_err_o(proto_err), .busy_o(busy), .pd_err_o(pd_err)
  );

  typedef enum int {K_OP, K_MREG, K_PROTO} kind_e;
  typedef struct {
    kind_e       kind;
    string       req;
    logic        wr;
    logic [1:0]  bank;
    logic [14:0] upper;
    logic [6:0]  lower;
    logic        ext;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0, fails = 0;
  bit done = 0;
  logic        cur_wr;
  logic [1:0]  cur_bank;
  logic [14:0] cur_upper;

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // one command cycle: drive after a falling edge, return after the next one
  task automatic cyc(logic c, logic f, logic [1:0] b, logic [14:0] a, logic p);
    cs = c; fn = f; ba = b; addr = a; pdn = p;
    @(negedge clk);
  endtask

  task automatic nop(logic p = 1'b1);
    cyc(1'b1, 1'b0, 2'b00, 15'h0, p);
  endtask

  task automatic first(logic wr, logic [1:0] b, logic [14:0] a, logic p = 1'b1);
    cur_wr = wr; cur_bank = b; cur_upper = a;
    cyc(1'b0, !wr, b, a, p);
  endtask

  task automatic lower(logic [14:0] a, string req, logic p = 1'b1);
    exp_t e;
    e.kind = K_OP; e.req = req; e.wr = cur_wr; e.bank = cur_bank;
    e.upper = cur_upper; e.lower = a[6:0]; e.ext = 1'b0;
    exp_q.push_back(e);
    cyc(1'b1, 1'b0, 2'b11, a, p);
  endtask

  task automatic mreg_cmd(string req);
    exp_t e;
    e.kind = K_MREG; e.req = req; e.wr = 1'b0; e.bank = '0;
    e.upper = cur_upper; e.lower = '0; e.ext = cur_bank[0];
    exp_q.push_back(e);
    cyc(1'b1, 1'b1, 2'b00, 15'h7FFF, 1'b1);
  endtask

  // monitor: every strobe must match the oldest expected item
  always @(negedge clk) begin
    if (!rst && (op_valid || mreg_load || proto_err)) begin
      if (exp_q.size() == 0) begin
        chk(0, "R7 unexpected strobe", {op_valid, mreg_load, proto_err}, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        case (e.kind)
          K_OP: begin
            chk(op_valid && !mreg_load && !proto_err, {e.req, " op strobe"},
                {op_valid, mreg_load, proto_err}, 3'b100);
            chk(op_bank == e.bank, {e.req, " bank R4"}, op_bank, e.bank);
            chk(op_upper == e.upper, {e.req, " upper"}, op_upper, e.upper);
            chk(op_lower == e.lower, {e.req, " lower"}, op_lower, e.lower);
            chk(op_write == e.wr, {e.req, " write"}, op_write, e.wr);
          end
          K_MREG: begin
            chk(mreg_load && !op_valid && !proto_err, {e.req, " load strobe"},
                {op_valid, mreg_load, proto_err}, 3'b010);
            chk(mreg_ext == e.ext, {e.req, " ext select"}, mreg_ext, e.ext);
            chk(mreg_data == e.upper, {e.req, " data"}, mreg_data, e.upper);
          end
          default: begin
            chk(proto_err && !op_valid && !mreg_load, {e.req, " proto strobe"},
                {op_valid, mreg_load, proto_err}, 3'b001);
          end
        endcase
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    exp_t pe;
    @(negedge clk); @(negedge clk); @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(!op_valid && !mreg_load && !proto_err, "R1 strobes", {op_valid, mreg_load, proto_err}, 0);
    chk(!busy && !pd_err, "R1 busy/pd", {busy, pd_err}, 0);

    // R2/R3 read pair, then R8 burst window
    first(1'b0, 2'b01, 15'h1234);
    chk(busy == 1'b1, "R2 busy after first", busy, 1);
    lower(15'h7F55, "R3 read");
    chk(busy == 1'b1, "R8 busy at completion", busy, 1);
    for (int i = 1; i < BURST; i++) nop();
    chk(busy == 1'b1, "R8 busy last burst cycle", busy, 1);
    nop();
    chk(busy == 1'b0, "R8 busy ends", busy, 0);

    // R4 every bank, writes
    for (int b = 0; b < 4; b++) begin
      first(1'b1, 2'(b), 15'h4000 | 15'(b * 3));
      lower(15'h7F80 | 15'(b * 17), "R4 write bank");
    end
    repeat (BURST + 1) nop();

    // R5 mode register pairs
    first(1'b0, 2'b01, 15'h2AAA);
    mreg_cmd("R5 extended");
    chk(busy == 1'b0, "R8 busy clear after mode pair", busy, 0);
    first(1'b1, 2'b10, 15'h0155);
    mreg_cmd("R5 regular");

    // R6 abort, then R7 lone second cycle is a no-op
    first(1'b0, 2'b00, 15'h0F0F);
    pe.kind = K_PROTO; pe.req = "R6 abort"; pe.wr = 0; pe.bank = 0;
    pe.upper = 0; pe.lower = 0; pe.ext = 0;
    exp_q.push_back(pe);
    cyc(1'b0, 1'b0, 2'b11, 15'h1111, 1'b1);
    chk(busy == 1'b0, "R6 idle after abort", busy, 0);
    cyc(1'b1, 1'b0, 2'b10, 15'h0033, 1'b1);
    chk(op_valid == 1'b0, "R7 lone lower ignored", op_valid, 0);
    cyc(1'b1, 1'b1, 2'b01, 15'h0044, 1'b1);
    chk(mreg_load == 1'b0, "R7 lone mode ignored", mreg_load, 0);

    // R9 power-down legality
    nop(1'b0);
    chk(pd_err == 1'b0, "R9 idle pd ok", pd_err, 1'b0);
    first(1'b0, 2'b11, 15'h3333, 1'b0);
    chk(pd_err == 1'b0, "R9 pd at first cmd ok", pd_err, 0);
    lower(15'h0022, "R9 op with pd", 1'b0);
    chk(pd_err == 1'b1, "R9 pd during completion", pd_err, 1);
    nop(1'b1);
    chk(pd_err == 1'b0, "R9 flag clears", pd_err, 0);
    nop(1'b0);
    chk(pd_err == 1'b1, "R9 pd during burst", pd_err, 1);
    // new pair inside the running burst
    first(1'b1, 2'b10, 15'h0ABC);
    lower(15'h0011, "R8 overlap pair");
    for (int i = 1; i < BURST; i++) nop();
    chk(busy == 1'b1, "R8 reload on overlap", busy, 1);
    nop();
    chk(busy == 1'b0, "R8 overlap ends", busy, 0);

    // R1 reset mid-pair
    first(1'b0, 2'b01, 15'h5555);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(busy == 1'b0, "R1 busy cleared by reset", busy, 0);
    cyc(1'b1, 1'b0, 2'b00, 15'h0001, 1'b1);
    chk(op_valid == 1'b0, "R1 no op after reset", op_valid, 0);

    repeat (3) nop();
    chk(exp_q.size() == 0, "R10 all expected strobes seen", exp_q.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule